// File: doc/BRIEF.md
# Two-Layout Register Address Pointer for a Dual-Port I/O Expander

This block is the addressing logic of an I/O expander with two 8-bit ports, A and B. Each port has eleven registers. A serial front end loads the block's 8-bit pointer with the address byte that follows a command. It then pulses a byte strobe for every data byte transferred. On each strobe the block computes the address of the following byte. It also decodes the current pointer into a register index, a port flag and a hit flag. The register file uses these three outputs.

Two address layouts are supported. In the split layout, port A occupies 00h..0Ah and port B occupies 10h..1Ah. Addresses between and beyond these ranges select nothing. In the paired layout, every A register is followed directly by its B partner, and the pairs cover 00h..15h. Automatic advance can be turned off. In that case the split layout keeps the pointer where it is, and the paired layout swaps between the two members of the addressed pair.

Both mode bits live in the configuration register, which both ports share. The block keeps its own copy of those bits and picks them out of writes to that register.

Top module: `xp_addr_ptr`

## Requirements
- R1: After reset the pointer is 00h, the layout is paired (`split_o`=0) and automatic advance is on (`seq_off_o`=0).
- R2: A load pulse places `load_addr_i` in the pointer one clock later. When a load and a byte strobe occur together, the byte strobe is ignored, including any configuration write it carries.
- R3: In the split layout with advance on, a byte moves the pointer up by one. From 0Ah it goes to 10h, and from 1Ah or any higher address it goes to 00h.
- R4: In the paired layout with advance on, a byte moves the pointer up by one. From 15h or any higher address it goes to 00h.
- R5: In the split layout with advance off, a byte leaves the pointer unchanged.
- R6: In the paired layout with advance off, a byte at an address of 15h or below inverts pointer bit 0, so the pointer alternates within the pair starting from whichever member was addressed.
- R7: In the paired layout, `hit_o` is 1 for addresses up to 15h. In that case `reg_idx_o` is the pointer shifted right by one and `port_o` is pointer bit 0 (1 = port B).
- R8: In the split layout, `port_o` is 1 for addresses of 10h and up. `reg_idx_o` is the offset from that port's base, and `hit_o` is 1 only when that offset is below 11. A miss drives `hit_o`, `port_o` and `reg_idx_o` to 0.
- R9: The configuration register is index 5 and is reachable through either port's address. A write byte to it copies data bit 7 into the layout (1 = split) and data bit 5 into advance-off. A write to an address that misses, or a read byte, leaves both modes unchanged.
- R10: The advance made on the byte that writes the configuration register follows the modes that were in force before that write. From the next pointer value on, decoding and advance use the new modes. The pointer value itself is not remapped.
- R11: Without a load or a byte strobe, the pointer and both modes hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load the pointer from `load_addr_i` |
| load_addr_i | input | 8 | Address byte taken from the front end |
| byte_i | input | 1 | One data byte transferred at the current pointer |
| byte_wr_i | input | 1 | The strobed byte is a write |
| wdata_i | input | 8 | Write data of the strobed byte |
| ptr_o | output | 8 | Current pointer |
| hit_o | output | 1 | Pointer selects a defined register |
| port_o | output | 1 | Selected port (0 = A, 1 = B) |
| reg_idx_o | output | 4 | Register index within the port, 0..10 |
| split_o | output | 1 | Layout in force (1 = split) |
| seq_off_o | output | 1 | Automatic advance disabled |

## Verification
A wrong pointer value appears on `ptr_o` and on the decode outputs on the clock right after the byte that produced it. Every later byte then stays misplaced until the next load. A wrong mode bit changes nothing until the next byte strobe, so the bench follows each configuration write with further bytes and checks the landing address. A configuration write sent to the wrong address, or one that is lost, shows up only a step later, through the advance pattern. The sequences therefore walk through the jump at the end of port A, through both wraps and through pair toggling after each mode change.

// File: rtl/xp_addr_pkg.sv
package xp_addr_pkg;
  localparam int IDX_W = 4;

  typedef enum logic {
    LAY_PAIRED = 1'b0,
    LAY_SPLIT  = 1'b1
  } layout_e;

  typedef struct packed {
    logic             hit;
    logic             port;
    logic [IDX_W-1:0] idx;
  } sel_t;
endpackage

// File: rtl/xp_ptr_step.sv
module xp_ptr_step
  import xp_addr_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NREG   = 11,
  parameter int B_BASE = 16
) (
  input  logic [AW-1:0] cur,
  input  layout_e       lay,
  input  logic          seq_off,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] A_LAST = AW'(NREG - 1);
  localparam logic [AW-1:0] B_FRST = AW'(B_BASE);
  localparam logic [AW-1:0] B_LAST = AW'(B_BASE + NREG - 1);
  localparam logic [AW-1:0] P_LAST = AW'(2 * NREG - 1);

  always_comb begin
    nxt = cur;
    if (!seq_off) begin
      if (lay == LAY_SPLIT) begin
        if (cur == A_LAST)       nxt = B_FRST;
        else if (cur >= B_LAST)  nxt = '0;
        else                     nxt = cur + AW'(1);
      end else begin
        if (cur >= P_LAST)       nxt = '0;
        else                     nxt = cur + AW'(1);
      end
    end else if (lay == LAY_PAIRED && cur <= P_LAST) begin
      nxt = {cur[AW-1:1], ~cur[0]};
    end
  end
endmodule

// File: rtl/xp_sel_decode.sv
module xp_sel_decode
  import xp_addr_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NREG   = 11,
  parameter int B_BASE = 16
) (
  input  logic [AW-1:0] cur,
  input  layout_e       lay,
  output sel_t          sel
);
  localparam logic [AW-1:0] B_FRST = AW'(B_BASE);
  localparam logic [AW-1:0] P_LAST = AW'(2 * NREG - 1);
  localparam logic [AW-1:0] N_V    = AW'(NREG);

  logic          in_b;
  logic [AW-1:0] off;

  always_comb begin
    in_b = (cur >= B_FRST);
    off  = in_b ? (cur - B_FRST) : cur;
    sel  = '0;
    if (lay == LAY_SPLIT) begin
      if (off < N_V) begin
        sel.hit  = 1'b1;
        sel.port = in_b;
        sel.idx  = off[IDX_W-1:0];
      end
    end else begin
      if (cur <= P_LAST) begin
        sel.hit  = 1'b1;
        sel.port = cur[0];
        sel.idx  = cur[IDX_W:1];
      end
    end
  end
endmodule

// File: rtl/xp_addr_ptr.sv
module xp_addr_ptr
  import xp_addr_pkg::*;
#(
  parameter int AW       = 8,
  parameter int NREG     = 11,
  parameter int B_BASE   = 16,
  parameter int CFG_IDX  = 5,
  parameter int BANK_BIT = 7,
  parameter int SEQ_BIT  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [AW-1:0]    load_addr_i,
  input  logic             byte_i,
  input  logic             byte_wr_i,
  input  logic [7:0]       wdata_i,
  output logic [AW-1:0]    ptr_o,
  output logic             hit_o,
  output logic             port_o,
  output logic [IDX_W-1:0] reg_idx_o,
  output logic             split_o,
  output logic             seq_off_o
);
  localparam logic [IDX_W-1:0] CFG_V = IDX_W'(CFG_IDX);

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [AW-1:0] ptr_q, ptr_d, step_nxt;
  layout_e       lay_q, lay_d;
  logic          seq_q, seq_d;
  logic          ptr_en, cfg_en;
  sel_t          sel;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  xp_ptr_step #(.AW(AW), .NREG(NREG), .B_BASE(B_BASE)) u_step (
    .cur(ptr_q), .lay(lay_q), .seq_off(seq_q), .nxt(step_nxt)
  );

  xp_sel_decode #(.AW(AW), .NREG(NREG), .B_BASE(B_BASE)) u_dec (
    .cur(ptr_q), .lay(lay_q), .sel(sel)
  );

  // next state
  always_comb begin
    ptr_en = load_i | byte_i;
    ptr_d  = load_i ? load_addr_i : step_nxt;
    cfg_en = byte_i & byte_wr_i & ~load_i & sel.hit & (sel.idx == CFG_V);
    lay_d  = layout_e'(wdata_i[BANK_BIT]);
    seq_d  = wdata_i[SEQ_BIT];
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ptr_q <= '0;
      lay_q <= LAY_PAIRED;
      seq_q <= 1'b0;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      if (cfg_en) begin
        lay_q <= lay_d;
        seq_q <= seq_d;
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign hit_o     = sel.hit;
  assign port_o    = sel.port;
  assign reg_idx_o = sel.idx;
  assign split_o   = (lay_q == LAY_SPLIT);
  assign seq_off_o = seq_q;
endmodule

// File: rtl/xp_addr_ptr_chk.sv
module xp_addr_ptr_chk #(
  parameter int AW       = 8,
  parameter int NREG     = 11,
  parameter int B_BASE   = 16,
  parameter int CFG_IDX  = 5,
  parameter int BANK_BIT = 7,
  parameter int SEQ_BIT  = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_i,
  input logic [AW-1:0] load_addr_i,
  input logic          byte_i,
  input logic          byte_wr_i,
  input logic [7:0]    wdata_i,
  input logic [AW-1:0] ptr_o,
  input logic          hit_o,
  input logic          port_o,
  input logic [3:0]    reg_idx_o,
  input logic          split_o,
  input logic          seq_off_o
);
  localparam logic [AW-1:0] A_LAST = AW'(NREG - 1);
  localparam logic [AW-1:0] B_FRST = AW'(B_BASE);
  localparam logic [AW-1:0] B_LAST = AW'(B_BASE + NREG - 1);
  localparam logic [AW-1:0] P_LAST = AW'(2 * NREG - 1);
  localparam logic [3:0]    CFG_V  = 4'(CFG_IDX);
  localparam logic [3:0]    N_V    = 4'(NREG);

  logic step;
  assign step = byte_i & ~load_i;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ptr_o == $past(load_addr_i)); // R2
  AST_SPLIT_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    step && split_o && !seq_off_o && ptr_o == A_LAST |=> ptr_o == B_FRST); // R3
  AST_SPLIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step && split_o && !seq_off_o && ptr_o >= B_LAST |=> ptr_o == '0); // R3
  AST_PAIR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !split_o && !seq_off_o && ptr_o >= P_LAST |=> ptr_o == '0); // R4
  AST_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    step && split_o && seq_off_o |=> $stable(ptr_o)); // R5
  AST_PAIR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step && !split_o && seq_off_o && ptr_o <= P_LAST
    |=> ptr_o == ($past(ptr_o) ^ AW'(1))); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> reg_idx_o < N_V); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> !port_o && reg_idx_o == '0); // R8
  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    step && byte_wr_i && hit_o && reg_idx_o == CFG_V
    |=> split_o == $past(wdata_i[BANK_BIT]) && seq_off_o == $past(wdata_i[SEQ_BIT])); // R9
  AST_READ_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_i && !byte_wr_i) || (byte_i && !hit_o) || load_i
    |=> $stable(split_o) && $stable(seq_off_o)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_i && !load_i |=> $stable(ptr_o) && $stable(split_o) && $stable(seq_off_o)); // R11
endmodule

bind xp_addr_ptr xp_addr_ptr_chk #(
  .AW(AW), .NREG(NREG), .B_BASE(B_BASE),
  .CFG_IDX(CFG_IDX), .BANK_BIT(BANK_BIT), .SEQ_BIT(SEQ_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .load_i(load_i), .load_addr_i(load_addr_i),
  .byte_i(byte_i), .byte_wr_i(byte_wr_i), .wdata_i(wdata_i),
  .ptr_o(ptr_o), .hit_o(hit_o), .port_o(port_o), .reg_idx_o(reg_idx_o),
  .split_o(split_o), .seq_off_o(seq_off_o)
);

// File: tb/test_xp_addr_ptr.sv
module test_xp_addr_ptr;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 32;

  // vector: op[23:22] (0 idle,1 load,2 read,3 write), data[21:14],
  //         exp ptr[13:6], exp hit[5], exp port[4], exp idx[3:0]
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    {2'd1, 8'h12, 8'h12, 1'b1, 1'b0, 4'd9 },  //  0 R2 R7 paired load
    {2'd2, 8'h00, 8'h13, 1'b1, 1'b1, 4'd9 },  //  1 R4
    {2'd2, 8'h00, 8'h14, 1'b1, 1'b0, 4'd10},  //  2 R4
    {2'd2, 8'h00, 8'h15, 1'b1, 1'b1, 4'd10},  //  3 R4
    {2'd2, 8'h00, 8'h00, 1'b1, 1'b0, 4'd0 },  //  4 R4 wrap after 15h
    {2'd1, 8'h16, 8'h16, 1'b0, 1'b0, 4'd0 },  //  5 R7 miss
    {2'd2, 8'h00, 8'h00, 1'b1, 1'b0, 4'd0 },  //  6 R4 wrap above 15h
    {2'd1, 8'h0B, 8'h0B, 1'b1, 1'b1, 4'd5 },  //  7 R9 config via port B
    {2'd3, 8'h20, 8'h0C, 1'b1, 1'b0, 4'd6 },  //  8 R10 advance-off set, old advance
    {2'd2, 8'h00, 8'h0D, 1'b1, 1'b1, 4'd6 },  //  9 R6 toggle
    {2'd2, 8'h00, 8'h0C, 1'b1, 1'b0, 4'd6 },  // 10 R6 toggle back
    {2'd1, 8'h0A, 8'h0A, 1'b1, 1'b0, 4'd5 },  // 11 R9 config via port A
    {2'd3, 8'hA0, 8'h0B, 1'b0, 1'b0, 4'd0 },  // 12 R10 toggle by old mode, split decode
    {2'd2, 8'h00, 8'h0B, 1'b0, 1'b0, 4'd0 },  // 13 R5 hold
    {2'd3, 8'h00, 8'h0B, 1'b0, 1'b0, 4'd0 },  // 14 R9 write to miss ignored
    {2'd1, 8'h05, 8'h05, 1'b1, 1'b0, 4'd5 },  // 15 R8
    {2'd2, 8'h00, 8'h05, 1'b1, 1'b0, 4'd5 },  // 16 R5 still advance-off
    {2'd1, 8'h15, 8'h15, 1'b1, 1'b1, 4'd5 },  // 17 R8 port B config
    {2'd3, 8'h80, 8'h15, 1'b1, 1'b1, 4'd5 },  // 18 R10 held by old mode
    {2'd2, 8'h00, 8'h16, 1'b1, 1'b1, 4'd6 },  // 19 R3 advance now on
    {2'd1, 8'h0A, 8'h0A, 1'b1, 1'b0, 4'd10},  // 20 R8
    {2'd2, 8'h00, 8'h10, 1'b1, 1'b1, 4'd0 },  // 21 R3 jump 0Ah->10h
    {2'd1, 8'h1A, 8'h1A, 1'b1, 1'b1, 4'd10},  // 22 R8
    {2'd2, 8'h00, 8'h00, 1'b1, 1'b0, 4'd0 },  // 23 R3 wrap after 1Ah
    {2'd1, 8'h0C, 8'h0C, 1'b0, 1'b0, 4'd0 },  // 24 R8 gap miss
    {2'd1, 8'h2A, 8'h2A, 1'b0, 1'b0, 4'd0 },  // 25 R8 high miss
    {2'd2, 8'h00, 8'h00, 1'b1, 1'b0, 4'd0 },  // 26 R3 wrap above 1Ah
    {2'd0, 8'h00, 8'h00, 1'b1, 1'b0, 4'd0 },  // 27 R11 idle
    {2'd1, 8'h05, 8'h05, 1'b1, 1'b0, 4'd5 },  // 28 R8
    {2'd2, 8'h00, 8'h06, 1'b1, 1'b0, 4'd6 },  // 29 R9 read of config keeps modes
    {2'd2, 8'h00, 8'h07, 1'b1, 1'b0, 4'd7 },  // 30 R3
    {2'd0, 8'h00, 8'h07, 1'b1, 1'b0, 4'd7 }   // 31 R11 idle
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0, byte_i = 1'b0, byte_wr_i = 1'b0;
  logic [7:0] load_addr_i = '0, wdata_i = '0;
  logic [7:0] ptr_o;
  logic       hit_o, port_o, split_o, seq_off_o;
  logic [3:0] reg_idx_o;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xp_addr_ptr i_xp_addr_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
    .byte_i(byte_i), .byte_wr_i(byte_wr_i), .wdata_i(wdata_i),
    .ptr_o(ptr_o), .hit_o(hit_o), .port_o(port_o), .reg_idx_o(reg_idx_o),
    .split_o(split_o), .seq_off_o(seq_off_o)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic by, input logic wr, input logic [7:0] d);
    @(negedge clk);
    load_i = ld; byte_i = by; byte_wr_i = wr; load_addr_i = d; wdata_i = d;
    @(negedge clk);
    load_i = 1'b0; byte_i = 1'b0; byte_wr_i = 1'b0;
  endtask

  task automatic chk_sel(input string req, input logic [7:0] p, input logic h, input logic pt, input logic [3:0] ix);
    chk(req, "ptr",  ptr_o, p);
    chk(req, "hit",  {7'd0, hit_o}, {7'd0, h});
    chk(req, "port", {7'd0, port_o}, {7'd0, pt});
    chk(req, "idx",  {4'd0, reg_idx_o}, {4'd0, ix});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    chk("R1", "ptr", ptr_o, 8'h00);
    chk("R1", "split", {7'd0, split_o}, 8'h00);
    chk("R1", "seq_off", {7'd0, seq_off_o}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_sel("R1", 8'h00, 1'b1, 1'b0, 4'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op;
      op = VEC[i][23:22];
      drive(op == 2'd1, op[1], op == 2'd3, VEC[i][21:14]);
      chk_sel($sformatf("vec%0d", i), VEC[i][13:6], VEC[i][5], VEC[i][4], VEC[i][3:0]);
    end
    chk("R9", "split", {7'd0, split_o}, 8'h01);
    chk("R9", "seq_off", {7'd0, seq_off_o}, 8'h00);

    // R2: load and byte together, byte ignored even as a config write
    drive(1'b1, 1'b0, 1'b0, 8'h05);
    drive(1'b1, 1'b1, 1'b1, 8'h03);
    chk_sel("R2", 8'h03, 1'b1, 1'b0, 4'd3);
    chk("R2", "split", {7'd0, split_o}, 8'h01);
    chk("R2", "seq_off", {7'd0, seq_off_o}, 8'h00);

    // R1: reset mid-run returns to the paired layout
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "ptr", ptr_o, 8'h00);
    chk("R1", "split", {7'd0, split_o}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 8'h0B);
    chk_sel("R1", 8'h0B, 1'b1, 1'b1, 4'd5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule